// File: doc/BRIEF.md
# Dual-Width Carry and Overflow Adder

This block is a 64-bit add and subtract datapath that computes a result together with two sets of status flags: a primary carry and overflow pair that follows the selected width mode, and a second pair that always describes the low 32-bit word. A mode bit selects whether the primary flags describe the full 64-bit result or the low word. Subtraction is done as the inverted first operand plus the second operand plus a carry, so every carry flag means "no borrow".

The caller supplies two operands, a four-bit operation code, the mode bit, an overflow-enable bit, and the current carry and sticky summary-overflow values. The result and all five flags are registered and appear one clock after the inputs are sampled. The overflow and low-word overflow flags are state inside the block. They hold their value whenever overflow-enable is clear.

Top module: `dual_flag_adder`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is 0 after that edge.
- R2: The result and flags for the inputs sampled at a rising edge appear on the outputs after that edge. `sum_out` is the 64-bit sum X + Y + c, with the operand X, the operand Y and the carry c chosen by `op_sel`. The codes are: 0 = A+B; 1 = ~A+B+1; 2 = A+B+carry_in; 3 = ~A+B+carry_in; 4 = A+all-ones+carry_in; 5 = ~A+all-ones+carry_in; 6 = A+0+carry_in; 7 = ~A+0+carry_in; 8 = negate, ~A+0+1.
- R3: For codes 0 to 7, `ca_out` is the carry out of bit 63 when `wide_mode`=1, and the carry out of bit 31 when `wide_mode`=0.
- R4: For codes 0 to 7, `ca32_out` is the carry out of bit 31 in both modes. It is updated in the same cycle as `ca_out`.
- R5: When `ov_en`=1 and the code is 0 to 7, `ov_out` is the XOR of the carry into and the carry out of bit 63 when `wide_mode`=1, and of bit 31 when `wide_mode`=0. `ov32_out` is the XOR of the carry into and the carry out of bit 31 in both modes.
- R6: For negate with `ov_en`=1, `ov_out` and `ov32_out` are both 1 exactly when the operand is 0x8000_0000_0000_0000 (`wide_mode`=1), or when its low word is 0x8000_0000 (`wide_mode`=0). Otherwise both are 0.
- R7: Negate leaves `ca_out` and `ca32_out` at their previous values and ignores `carry_in`.
- R8: When `ov_en`=1, `so_out` becomes `so_in` OR the new `ov_out`. When `ov_en`=0, `ov_out` and `ov32_out` keep their values and `so_out` becomes `so_in`.
- R9: The unused codes 9 to 15 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation code |
| wide_mode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| ov_en | input | 1 | Overflow-enable |
| carry_in | input | 1 | Current carry value |
| so_in | input | 1 | Current summary-overflow value |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| sum_out | output | 64 | Registered result |
| ca_out | output | 1 | Mode-dependent carry |
| ca32_out | output | 1 | Low-word carry |
| ov_out | output | 1 | Mode-dependent signed overflow |
| ov32_out | output | 1 | Low-word signed overflow |
| so_out | output | 1 | Sticky summary overflow |

## Verification
Two things happen in the same cycle: the mode-dependent flags and the low-word flags are both written from one sum, and the two can disagree. The bench provokes this with operands whose low word overflows but whose full word does not, and the reverse, in both modes. It checks both pairs of flags against values worked out by hand. In the same way, a negate with `ov_en`=1 updates the overflow flags while it holds the carry flags. The bench drives `carry_in` to the opposite value to show that the carry flags keep their previous values.

// File: rtl/dual_flag_adder.sv
module dual_flag_adder #(
  parameter int W = 64,
  parameter int LW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_sel,
  input  logic         wide_mode,
  input  logic         ov_en,
  input  logic         carry_in,
  input  logic         so_in,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] sum_out,
  output logic         ca_out,
  output logic         ca32_out,
  output logic         ov_out,
  output logic         ov32_out,
  output logic         so_out
);
  logic [3:0]   op;
  logic         is_neg, inv_a, cin;
  logic [W-1:0] x, y;
  logic [W:0]   full;
  logic [LW:0]  low;
  logic         c_lo_in, c_lo_out, c_hi_in, c_hi_out;
  logic         ovf_lo, ovf_hi, ovf_mode, ovf_lo_n, ca_mode;
  logic         neg_min;

  assign op     = (op_sel > 4'd8) ? 4'd0 : op_sel;
  assign is_neg = (op == 4'd8);
  assign inv_a  = op[0] | is_neg;
  assign x      = inv_a ? ~opa : opa;

  always_comb begin
    if (is_neg) begin
      y   = '0;
      cin = 1'b1;
    end else begin
      case (op[2:1])
        2'b00: begin y = opb;  cin = op[0];    end
        2'b01: begin y = opb;  cin = carry_in; end
        2'b10: begin y = '1;   cin = carry_in; end
        default: begin y = '0; cin = carry_in; end
      endcase
    end
  end

  assign full     = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign low      = {1'b0, x[LW-1:0]} + {1'b0, y[LW-1:0]} + {{LW{1'b0}}, cin};
  assign c_hi_out = full[W];
  assign c_hi_in  = x[W-1] ^ y[W-1] ^ full[W-1];
  assign c_lo_out = low[LW];
  assign c_lo_in  = x[LW-1] ^ y[LW-1] ^ low[LW-1];
  assign ovf_hi   = c_hi_in ^ c_hi_out;
  assign ovf_lo   = c_lo_in ^ c_lo_out;
  assign ca_mode  = wide_mode ? c_hi_out : c_lo_out;

  assign neg_min  = wide_mode ? (opa == {1'b1, {(W-1){1'b0}}})
                              : (opa[LW-1:0] == {1'b1, {(LW-1){1'b0}}});
  assign ovf_mode = is_neg ? neg_min : (wide_mode ? ovf_hi : ovf_lo);
  assign ovf_lo_n = is_neg ? neg_min : ovf_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_out  <= '0;
      ca_out   <= 1'b0;
      ca32_out <= 1'b0;
      ov_out   <= 1'b0;
      ov32_out <= 1'b0;
      so_out   <= 1'b0;
    end else begin
      sum_out <= full[W-1:0];
      if (!is_neg) begin
        ca_out   <= ca_mode;
        ca32_out <= c_lo_out;
      end
      if (ov_en) begin
        ov_out   <= ovf_mode;
        ov32_out <= ovf_lo_n;
        so_out   <= so_in | ovf_mode;
      end else begin
        so_out   <= so_in;
      end
    end
  end
endmodule

module dual_flag_adder_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_sel,
  input logic         wide_mode,
  input logic         ov_en,
  input logic         carry_in,
  input logic         so_in,
  input logic [W-1:0] opa,
  input logic [W-1:0] sum_out,
  input logic         ca_out,
  input logic         ca32_out,
  input logic         ov_out,
  input logic         ov32_out,
  input logic         so_out
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (sum_out == '0 && !ca_out && !ca32_out && !ov_out && !ov32_out && !so_out));

  assert_narrow_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && op_sel != 4'd8) |=> (ca_out == ca32_out));

  assert_narrow_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_en && !wide_mode) |=> (ov_out == ov32_out));

  assert_neg_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_en && wide_mode && op_sel == 4'd8 && opa == {1'b1, {(W-1){1'b0}}}) |=> (ov_out && ov32_out));

  assert_neg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd8) |=> ($stable(ca_out) && $stable(ca32_out)));

  assert_ovf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ov_en |=> ($stable(ov_out) && $stable(ov32_out) && so_out == $past(so_in)));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ov_en |=> (so_out == ($past(so_in) | ov_out)));

  wire unused_ok = carry_in;
endmodule

bind dual_flag_adder dual_flag_adder_chk #(.W(W)) u_chk (.*);

// File: tb/sim_dual_flag_adder.sv
`timescale 1ns/1ps
module sim_dual_flag_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic        wide_mode = 1'b1, ov_en = 1'b0, carry_in = 1'b0, so_in = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic [63:0] sum_out;
  logic        ca_out, ca32_out, ov_out, ov32_out, so_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_flag_adder u0 (.*);

  typedef struct packed {
    logic [3:0]  op;
    logic        m64, oe, cin, soi;
    logic [63:0] a, b, res;
    logic [4:0]  fl; // {ca, ca32, ov, ov32, so}
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFF_FFFFFFFF, 64'h1, 64'h0, 5'b11000},
    '{4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h7FFFFFFF_FFFFFFFF, 64'h1, 64'h80000000_00000000, 5'b01101},
    '{4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h7FFFFFFF_FFFFFFFF, 64'h1, 64'h80000000_00000000, 5'b11001},
    '{4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h00000000_7FFFFFFF, 64'h1, 64'h00000000_80000000, 5'b00111},
    '{4'd2, 1'b1, 1'b1, 1'b1, 1'b0, 64'h1, 64'h2, 64'h4, 5'b00000},
    '{4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h5, 64'h3, 64'hFFFFFFFF_FFFFFFFE, 5'b00000},
    '{4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h3, 64'h5, 64'h2, 5'b11000},
    '{4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 64'h3, 64'h5, 64'h1, 5'b11000},
    '{4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 5'b00000},
    '{4'd4, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0, 64'h0, 64'h0, 5'b11000},
    '{4'd5, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 5'b11000},
    '{4'd6, 1'b1, 1'b1, 1'b1, 1'b0, 64'h00000000_FFFFFFFF, 64'h0, 64'h00000001_00000000, 5'b01000},
    '{4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 64'h1, 64'h0, 64'hFFFFFFFF_FFFFFFFE, 5'b00000},
    '{4'd8, 1'b1, 1'b1, 1'b1, 1'b0, 64'h80000000_00000000, 64'h0, 64'h80000000_00000000, 5'b00111},
    '{4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 64'hFFFFFFFF_80000000, 64'h0, 64'h00000000_80000000, 5'b00111},
    '{4'd8, 1'b1, 1'b1, 1'b1, 1'b0, 64'h00000000_80000000, 64'h0, 64'hFFFFFFFF_80000000, 5'b00000},
    '{4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 64'h5, 64'h0, 64'hFFFFFFFF_FFFFFFFB, 5'b00000}
  };

  task automatic drive(input logic [3:0] op, input logic m, input logic oe,
                       input logic ci, input logic si, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_sel = op; wide_mode = m; ov_en = oe; carry_in = ci; so_in = si; opa = a; opb = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] er, input logic [4:0] ef);
    logic [4:0] af;
    af = {ca_out, ca32_out, ov_out, ov32_out, so_out};
    n_cmp++;
    if (sum_out !== er || af !== ef) begin
      n_bad++;
      $display("FAIL %s: got res=%h flags=%b, expected res=%h flags=%b", tag, sum_out, af, er, ef);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 64'h0, 5'b00000);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7 R8 table walk
    for (int i = 0; i < NV; i++) begin
      drive(VT[i].op, VT[i].m64, VT[i].oe, VT[i].cin, VT[i].soi, VT[i].a, VT[i].b);
      check($sformatf("R2/R3/R4/R5/R6/R7/R8 row %0d", i), VT[i].res, VT[i].fl);
    end

    drive(4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h7FFFFFFF_FFFFFFFF, 64'h1);
    check("R5 wide overflow set", 64'h80000000_00000000, 5'b01101);
    drive(4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h00000000_7FFFFFFF, 64'h1);
    check("R8 overflow held with ov_en clear", 64'h00000000_80000000, 5'b00100);
    drive(4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h1, 64'h1);
    check("R8 so passes so_in with ov_en clear", 64'h2, 5'b00101);

    drive(4'd12, 1'b1, 1'b1, 1'b1, 1'b0, 64'hFFFFFFFF_FFFFFFFF, 64'h1);
    check("R9 unused code acts as plain add", 64'h0, 5'b11000);
    drive(4'd15, 1'b1, 1'b1, 1'b1, 1'b0, 64'h7FFFFFFF_FFFFFFFF, 64'h1);
    check("R9 unused code 15 overflow", 64'h80000000_00000000, 5'b01101);

    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 reset mid-run", 64'h0, 5'b00000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule